// File: doc/BRIEF.md
# Privileged Status Mask Set Unit

This unit carries out the "set system mask" step of a processor's status-register handling. A valid operation arrives with a qualifying predicate bit, a 24-bit immediate and the current contents of the status register. The unit checks three conditions in a fixed priority order: privilege level, reserved mask bits, and virtualization mode. It then does one of two things. It raises exactly one fault, or it produces a new status value in which every set bit of the immediate is ORed into status bits 23:0.

All results are registered and appear one clock after the operation is presented. The new value goes out on a write port (`psr_we`, `psr_wdata`) that the owning register file consumes. Each committed update also sets a serialize-pending flag. The flag stays set until the pipeline acknowledges that a serialization has happened. The unit does not do instruction decode, fault delivery or the serialization itself.

Top module: `sysmask_set_unit`

## Requirements
- R1: When `op_valid` is 0 or `op_pred` is 0, no fault output and no write enable is raised in the following cycle.
- R2: When an operation is taken and the privilege field (status bits 33:32) is not 0, `flt_priv` is 1 in the following cycle and no write occurs.
- R3: When privilege is 0 and the immediate has any of bits 0, 6 to 12 or 16 set, `flt_rsvd` is 1 in the following cycle and no write occurs.
- R4: When privilege is 0, no reserved bit is set and the virtualization bit (status bit 46) is 1, `flt_virt` is 1 in the following cycle and no write occurs.
- R5: When every check passes, `psr_we` is 1 for exactly the following cycle and `psr_wdata[23:0]` equals the old bits 23:0 ORed with the immediate. Only bits 1 to 5, 13 to 15 and 17 to 23 can be set this way.
- R6: On a write, `psr_wdata` bits above 23 equal the same bits of the status value that was presented.
- R7: At most one of `flt_priv`, `flt_rsvd`, `flt_virt` and `psr_we` is 1 in any cycle, and `psr_wdata` is zero whenever `psr_we` is 0.
- R8: `ser_pending` becomes 1 together with every write and stays 1 until a cycle in which `ser_ack` is 1. If a commit and `ser_ack` fall in the same cycle, the flag is set.
- R9: While `rst_n` is 0 (synchronous), all outputs are 0 after the next clock edge, and this includes a pending serialization.
- R10: The interrupt-enable bit (bit 14) is set through the same OR path as every other writable bit, with no extra condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_pred | input | 1 | Qualifying predicate of the operation |
| op_imm | input | 24 | Bits to set in the mask field |
| psr_cur | input | PSR_W | Current status register value |
| ser_ack | input | 1 | Serialization completed; clears the pending flag |
| psr_we | output | 1 | Status register write enable |
| psr_wdata | output | PSR_W | Status register write value |
| flt_priv | output | 1 | Privileged-operation fault |
| flt_rsvd | output | 1 | Reserved-field fault |
| flt_virt | output | 1 | Virtualization fault |
| ser_pending | output | 1 | A committed update awaits serialization |

## Verification
The checker observes every cycle. On each cycle it checks that the three faults and the write enable are mutually exclusive, and that the write data is zero when no write occurs. It checks that a privileged or reserved-bit violation is answered by the matching fault, and that an unqualified operation causes nothing. It also checks that the upper status bits pass through on a write, and that the pending flag tracks commits and acknowledges. The bench sweeps every combination of valid, predicate, privilege level and virtualization bit against single-bit and full immediates. Only that sweep shows three things: the exact OR result per bit, the priority between simultaneous violations, and that the interrupt-enable bit behaves like its neighbours.

// File: rtl/sms_pkg.sv
// Package: shared types and constants of the status mask set unit.
// Assumes the mask field is the low 24 bits of the status register.
package sms_pkg;
    localparam int IMM_W = 24;

    // Outcome of one operation, in decreasing priority order of faults.
    typedef enum logic [2:0] {
        VD_IDLE   = 3'd0,
        VD_PRIV   = 3'd1,
        VD_RSVD   = 3'd2,
        VD_VIRT   = 3'd3,
        VD_COMMIT = 3'd4
    } verdict_e;

    // Bits of the mask field that software may set.
    function automatic logic [IMM_W-1:0] writable_mask();
        logic [IMM_W-1:0] m;
        for (int b = 0; b < IMM_W; b++) begin
            m[b] = (b >= 1 && b <= 5) || (b >= 13 && b <= 15) || (b >= 17);
        end
        return m;
    endfunction
endpackage

// File: rtl/sms_check.sv
// Module: sms_check
// Decides the outcome of one operation with combinational logic.
// Priority: privilege, then reserved bits, then virtualization.
// Assumes cpl and vm are already extracted from the status register.
module sms_check
    import sms_pkg::*;
#(
    parameter int CPL_W = 2
) (
    input  logic             take,
    input  logic [IMM_W-1:0] imm,
    input  logic [CPL_W-1:0] cpl,
    input  logic             vm,
    output verdict_e         verdict
);
    localparam logic [IMM_W-1:0] RSV_MASK = ~writable_mask();

    // Pick the single outcome by fixed priority.
    always_comb begin
        if (!take)                      verdict = VD_IDLE;
        else if (cpl != '0)             verdict = VD_PRIV;
        else if ((imm & RSV_MASK) != 0) verdict = VD_RSVD;
        else if (vm)                    verdict = VD_VIRT;
        else                            verdict = VD_COMMIT;
    end
endmodule

// File: rtl/sms_merge.sv
// Module: sms_merge
// Builds the candidate status value: the mask field ORed with the
// immediate, and every bit above the field passed through.
// Assumes PSR_W > IMM_W.
module sms_merge
    import sms_pkg::*;
#(
    parameter int PSR_W = 64
) (
    input  logic [PSR_W-1:0] cur,
    input  logic [IMM_W-1:0] imm,
    output logic [PSR_W-1:0] merged
);
    for (genvar g = 0; g < PSR_W; g++) begin : g_bit
        if (g < IMM_W) begin : g_mask
            // Field bit: set when the immediate bit is set.
            assign merged[g] = cur[g] | imm[g];
        end else begin : g_pass
            // Upper bit: untouched by this operation.
            assign merged[g] = cur[g];
        end
    end
endmodule

// File: rtl/sms_flag.sv
// Module: sms_flag
// Serialize-pending flag. A set request wins over a clear request
// in the same cycle. Synchronous active-low reset.
module sms_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    // Hold the flag from commit until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (set) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end
endmodule

// File: rtl/sysmask_set_unit.sv
// Module: sysmask_set_unit (top)
// Executes a predicated set-system-mask operation with fault checks.
// All outputs are registered: results appear one cycle after the
// operation is presented. Assumes the privilege field sits at
// CPL_LSB and the virtualization bit at VM_BIT, both above the mask field.
module sysmask_set_unit
    import sms_pkg::*;
#(
    parameter int PSR_W   = 64,
    parameter int CPL_LSB = 32,
    parameter int CPL_W   = 2,
    parameter int VM_BIT  = 46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_pred,
    input  logic [23:0]      op_imm,
    input  logic [PSR_W-1:0] psr_cur,
    input  logic             ser_ack,
    output logic             psr_we,
    output logic [PSR_W-1:0] psr_wdata,
    output logic             flt_priv,
    output logic             flt_rsvd,
    output logic             flt_virt,
    output logic             ser_pending
);
    verdict_e         verdict;
    logic [PSR_W-1:0] merged;
    logic             commit;

    sms_check #(.CPL_W(CPL_W)) u_check (
        .take    (op_valid & op_pred),
        .imm     (op_imm),
        .cpl     (psr_cur[CPL_LSB +: CPL_W]),
        .vm      (psr_cur[VM_BIT]),
        .verdict (verdict)
    );

    sms_merge #(.PSR_W(PSR_W)) u_merge (
        .cur    (psr_cur),
        .imm    (op_imm),
        .merged (merged)
    );

    assign commit = (verdict == VD_COMMIT);

    // Register the outcome onto the fault and write-port outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psr_we    <= 1'b0;
            psr_wdata <= '0;
            flt_priv  <= 1'b0;
            flt_rsvd  <= 1'b0;
            flt_virt  <= 1'b0;
        end else begin
            psr_we    <= commit;
            psr_wdata <= commit ? merged : '0;
            flt_priv  <= (verdict == VD_PRIV);
            flt_rsvd  <= (verdict == VD_RSVD);
            flt_virt  <= (verdict == VD_VIRT);
        end
    end

    sms_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (commit),
        .clr   (ser_ack),
        .pend  (ser_pending)
    );
endmodule

// File: rtl/sms_props.sv
// Module: sms_props
// Checker for sysmask_set_unit, attached with bind. Only observes ports.
module sms_props
    import sms_pkg::*;
#(
    parameter int PSR_W   = 64,
    parameter int CPL_LSB = 32,
    parameter int CPL_W   = 2,
    parameter int VM_BIT  = 46
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_pred,
    input logic [23:0]      op_imm,
    input logic [PSR_W-1:0] psr_cur,
    input logic             ser_ack,
    input logic             psr_we,
    input logic [PSR_W-1:0] psr_wdata,
    input logic             flt_priv,
    input logic             flt_rsvd,
    input logic             flt_virt,
    input logic             ser_pending
);
    localparam logic [23:0] RSV = ~writable_mask();

    a_r1_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_pred) |=> !(flt_priv || flt_rsvd || flt_virt || psr_we));

    a_r2_priv_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_pred && psr_cur[CPL_LSB +: CPL_W] != '0) |=> (flt_priv && !psr_we));

    a_r3_rsvd_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_pred && psr_cur[CPL_LSB +: CPL_W] == '0 && (op_imm & RSV) != 0)
        |=> (flt_rsvd && !psr_we));

    a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_pred) |=> (!psr_we || psr_wdata[PSR_W-1:24] == $past(psr_cur[PSR_W-1:24])));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_priv, flt_rsvd, flt_virt, psr_we}));

    a_r7_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !psr_we |-> psr_wdata == '0);

    a_r8_set_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        psr_we |-> ser_pending);

    a_r8_clear_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ser_ack |=> (!ser_pending || psr_we));
endmodule

bind sysmask_set_unit sms_props #(
    .PSR_W(PSR_W), .CPL_LSB(CPL_LSB), .CPL_W(CPL_W), .VM_BIT(VM_BIT)
) u_props (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_pred(op_pred),
    .op_imm(op_imm), .psr_cur(psr_cur), .ser_ack(ser_ack), .psr_we(psr_we),
    .psr_wdata(psr_wdata), .flt_priv(flt_priv), .flt_rsvd(flt_rsvd),
    .flt_virt(flt_virt), .ser_pending(ser_pending)
);

// File: tb/sysmask_set_unit_tb.sv
module sysmask_set_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PSR_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0, op_pred = 1'b0, ser_ack = 1'b0;
    logic [23:0]      op_imm = '0;
    logic [PSR_W-1:0] psr_cur = '0;
    logic             psr_we, flt_priv, flt_rsvd, flt_virt, ser_pending;
    logic [PSR_W-1:0] psr_wdata;

    int n_vec = 0, n_chk = 0, n_fail = 0, cycles = 0;
    logic exp_pend = 1'b0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    sysmask_set_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_pred(op_pred),
        .op_imm(op_imm), .psr_cur(psr_cur), .ser_ack(ser_ack), .psr_we(psr_we),
        .psr_wdata(psr_wdata), .flt_priv(flt_priv), .flt_rsvd(flt_rsvd),
        .flt_virt(flt_virt), .ser_pending(ser_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is a failure but still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Writable bits per R5: 1..5, 13..15, 17..23.
    function automatic logic [23:0] wr_bits();
        logic [23:0] m = '0;
        m[5:1] = '1; m[15:13] = '1; m[23:17] = '1;
        return m;
    endfunction

    // Apply one operation at the falling edge, then check one cycle later.
    task automatic apply(input logic v, input logic p, input logic [23:0] imm,
                         input logic [63:0] psr, input logic ack);
        logic take, pv, rv, vv, cm;
        string tag;
        @(negedge clk);
        op_valid = v; op_pred = p; op_imm = imm; psr_cur = psr; ser_ack = ack;
        take = v && p;
        pv = take && psr[33:32] != 2'b00;
        rv = take && !pv && (imm & ~wr_bits()) != 0;
        vv = take && !pv && !rv && psr[46];
        cm = take && !pv && !rv && !vv;
        exp_pend = cm ? 1'b1 : (ack ? 1'b0 : exp_pend);
        tag = !take ? "R1" : pv ? "R2" : rv ? "R3" : vv ? "R4" : "R5";
        @(negedge clk);
        n_vec++;
        check({tag, " faults/we"}, {60'd0, flt_priv, flt_rsvd, flt_virt, psr_we},
              {60'd0, pv, rv, vv, cm});
        if (cm) begin
            check("R5 mask field", {40'd0, psr_wdata[23:0]}, {40'd0, psr[23:0] | imm});
            check("R6 upper bits", {24'd0, psr_wdata[63:24]}, {24'd0, psr[63:24]});
            if (imm == 24'h004000)
                check("R10 i bit", {63'd0, psr_wdata[14]}, 64'd1);
        end else begin
            check("R7 idle data", psr_wdata, 64'd0);
        end
        check("R8 pending", {63'd0, ser_pending}, {63'd0, exp_pend});
    endtask

    initial begin
        // R9: reset state
        repeat (2) @(negedge clk);
        n_vec++;
        check("R9 reset outputs", {psr_wdata[59:0], flt_priv, flt_rsvd, flt_virt, psr_we},
              64'd0);
        check("R9 reset pending", {63'd0, ser_pending}, 64'd0);
        rst_n = 1'b1;

        // Sweep valid, predicate, privilege, vm and immediate patterns.
        for (int v = 0; v < 2; v++)
            for (int p = 0; p < 2; p++)
                for (int c = 0; c < 4; c++)
                    for (int m = 0; m < 2; m++)
                        for (int k = 0; k < 27; k++) begin
                            logic [23:0] imm;
                            logic [63:0] psr;
                            imm = (k < 24) ? (24'd1 << k) : (k == 24) ? 24'd0 :
                                  (k == 25) ? wr_bits() : 24'hFFFFFF;
                            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
                            psr = lfsr;
                            psr[33:32] = c[1:0];
                            psr[46] = m[0];
                            apply(v[0], p[0], imm, psr, (k % 5) == 0);
                        end

        // R8: commit with simultaneous acknowledge keeps the flag set.
        apply(1'b1, 1'b1, 24'h000002, 64'd0, 1'b1);
        apply(1'b0, 1'b0, 24'h0, 64'd0, 1'b0);
        apply(1'b0, 1'b0, 24'h0, 64'd0, 1'b1);

        // R9: reset clears a pending serialization.
        apply(1'b1, 1'b1, 24'h800000, 64'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0;
        @(negedge clk);
        n_vec++;
        check("R9 reset clears pending", {63'd0, ser_pending}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule